// File: doc/BRIEF.md
# Receive chunk deframer

This block sits on the host side of a serial MAC-PHY link. It accepts the receive byte stream that the SPI shifter collects from MISO, one chunk at a time. Each chunk is 64 payload bytes followed by a 4-byte footer. Because the footer says where frame data starts and ends inside the payload, the whole payload is held in a local buffer. Only once the footer has been decoded are the selected bytes released on a byte-wide valid/ready stream, with start-of-frame and end-of-frame markers.

The footer also carries error indications, an extended-status request, a synchronisation flag and the number of receive chunks still pending in the PHY. The block passes on the error and status events as one-cycle pulses. It keeps the pending-chunk count that the transfer scheduler uses to decide how many chunks to clock next. A frame that cannot be finished cleanly is closed with a terminator beat that carries the error marker. Downstream logic therefore always sees each started frame end exactly once.

Top module: `rx_chunk_deframer`

## Requirements
- R1: A chunk is 64 payload bytes followed by 4 footer bytes, accepted on `in_valid_i && in_ready_o`. `in_ready_o` is high while idle. After the last footer byte is accepted, it stays low until every output beat planned for that chunk has been handed over, and it returns high in the cycle after the final beat.
- R2: The footer is a 32-bit word sent most significant byte first. Its fields are: bit 31 extended status, bit 30 frame-drop error, bit 29 sync, bit 21 data valid, bit 20 start valid, bits 19:16 start offset in 4-byte words, bit 14 end valid, bits 13:8 index of the last frame byte, bits 5:1 pending receive chunks, and bit 0 chosen so that the whole word has an odd number of ones.
- R3: A footer whose word has an even number of ones discards the chunk. It pulses `rx_err_o`, leaves the pending count unchanged, and, if a frame is open, emits one terminator beat.
- R4: `cnt_load_i` loads `cnt_load_val_i` into the pending count. Every footer with correct parity replaces the pending count with its pending-chunks field. Both changes show on `pend_cnt_o` in the cycle after the edge. Nothing else changes the count.
- R5: With data valid and start valid set, a new frame begins at byte 4 × start offset, flagged with `out_sof_o`. It runs to the end index with `out_eof_o` when end valid is set and the end index is not below the start. Otherwise it runs to byte 63 and stays open.
- R6: With data valid set, a frame open and start valid clear, the chunk continues the frame. The bytes from 0 up to the end index are sent, the last one with `out_eof_o`, when end valid is set. Otherwise all 64 bytes are sent.
- R7: A terminator beat has `out_eof_o` and `out_err_o` set and data 0x00. When start valid arrives while a frame is open, the open frame is closed first. If end valid is set and the end index is below the new start, it closes normally with bytes 0 up to the end index. Otherwise it closes with a terminator beat, and the new frame's bytes follow.
- R8: With data valid clear, no beats are produced and an open frame stays open. Payload bytes with no open frame and no start are dropped.
- R9: A footer with sync clear, or with the frame-drop bit set, discards the chunk and emits a terminator if a frame is open. Frame-drop also pulses `rx_err_o`; sync clear alone does not.
- R10: When `zero_align_i` is high, a footer with data valid, start valid and a nonzero start offset is treated as an error. The chunk is discarded, `rx_err_o` pulses, and an open frame gets a terminator. A zero start offset is handled normally.
- R11: `exst_o` pulses for one cycle after a footer with correct parity and the extended-status bit set.
- R12: While `out_valid_o` is high and `out_ready_i` is low, the beat and its markers hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zero_align_i | input | 1 | Frames must start at payload byte 0 |
| in_valid_i | input | 1 | Received byte available |
| in_data_i | input | 8 | Received byte |
| in_ready_o | output | 1 | Block accepts a received byte |
| cnt_load_i | input | 1 | Load pending count from buffer status |
| cnt_load_val_i | input | 5 | Value loaded into the pending count |
| out_valid_o | output | 1 | Frame beat available |
| out_ready_i | input | 1 | Consumer takes the beat |
| out_data_o | output | 8 | Frame byte (0x00 on a terminator) |
| out_sof_o | output | 1 | First byte of a frame |
| out_eof_o | output | 1 | Last beat of a frame |
| out_err_o | output | 1 | Terminator beat: frame ended in error |
| rx_err_o | output | 1 | One-cycle receive error pulse |
| exst_o | output | 1 | One-cycle extended-status pulse |
| pend_cnt_o | output | 5 | Receive chunks still pending |

## Verification
The edge that accepts the fourth footer byte also updates the error pulse, the status pulse and the pending count. In the same cycle the first output beat is offered. The bench therefore reads all of these, and `in_ready_o`, at the falling edge right after that byte's handshake. It then waits for `in_ready_o` to return before comparing the beats it gathered at falling edges against a per-byte model of each chunk. The consumer's ready is toggled at random just after rising edges, so the stalled beats of R12 occur throughout the run.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int OFS_W     = 6;
  localparam int RCA_W     = 5;
  localparam int FTR_BYTES = 4;

  typedef struct packed {
    logic             exst;
    logic             fdrop;
    logic             sync;
    logic             dv;
    logic             sv;
    logic [3:0]       swo;
    logic             ev;
    logic [OFS_W-1:0] ebo;
    logic [RCA_W-1:0] rca;
    logic             par_ok;
  } ftr_t;

  typedef struct packed {
    logic             a_en;
    logic [OFS_W-1:0] a_hi;
    logic             a_eof;
    logic             t_en;
    logic             b_en;
    logic [OFS_W-1:0] b_lo;
    logic [OFS_W-1:0] b_hi;
    logic             b_eof;
  } plan_t;

  typedef enum logic [1:0] {S_IDLE, S_A, S_T, S_B} em_st_e;

  // Split the footer word into fields; parity is odd over all 32 bits.
  function automatic ftr_t ftr_unpack(input logic [31:0] w);
    ftr_t f;
    f.exst   = w[31];
    f.fdrop  = w[30];
    f.sync   = w[29];
    f.dv     = w[21];
    f.sv     = w[20];
    f.swo    = w[19:16];
    f.ev     = w[14];
    f.ebo    = w[13:8];
    f.rca    = w[5:1];
    f.par_ok = ^w;
    return f;
  endfunction

  // Byte index of a frame start given a word offset.
  function automatic logic [OFS_W-1:0] start_byte(input logic [3:0] swo);
    return {swo, 2'b00};
  endfunction

  // Segment that follows the current one (idle = chunk just decoded).
  function automatic em_st_e next_seg(input plan_t p, input em_st_e cur);
    if (cur == S_IDLE && p.a_en)                       return S_A;
    else if ((cur == S_IDLE || cur == S_A) && p.t_en)  return S_T;
    else if (cur != S_B && p.b_en)                     return S_B;
    else                                               return S_IDLE;
  endfunction
endpackage

// File: rtl/rxd_capture.sv
module rxd_capture
  import rxd_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic [7:0]       byte_i,
  input  logic [OFS_W-1:0] rd_idx_i,
  output logic [7:0]       rd_byte_o,
  output logic             ftr_done_o,
  output logic [31:0]      ftr_word_o
);
  localparam int CHUNK_BYTES = PAYLOAD_BYTES + FTR_BYTES;
  localparam int POS_W       = $clog2(CHUNK_BYTES);

  logic [POS_W-1:0] pos_q;
  logic [7:0]       buf_q [PAYLOAD_BYTES];
  logic [23:0]      ftr_sr_q;
  logic             in_payload;
  logic             last_byte;

  assign in_payload = pos_q < POS_W'(PAYLOAD_BYTES);
  assign last_byte  = pos_q == POS_W'(CHUNK_BYTES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     pos_q <= '0;
    else if (acc_i) pos_q <= last_byte ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (acc_i && in_payload) buf_q[pos_q[OFS_W-1:0]] <= byte_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   ftr_sr_q <= '0;
    else if (acc_i && !in_payload) ftr_sr_q <= {ftr_sr_q[15:0], byte_i};
  end

  assign rd_byte_o  = buf_q[rd_idx_i];
  assign ftr_done_o = acc_i && last_byte;
  assign ftr_word_o = {ftr_sr_q, byte_i};

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_W'(CHUNK_BYTES - 1))
    else $error("byte position past end of chunk");
endmodule

// File: rtl/rxd_footer_decode.sv
module rxd_footer_decode
  import rxd_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 64
) (
  input  logic [31:0]      ftr_word_i,
  input  logic             open_i,
  input  logic             zero_align_i,
  output plan_t            plan_o,
  output logic             open_next_o,
  output logic             err_o,
  output logic             exst_o,
  output logic             upd_o,
  output logic [RCA_W-1:0] rca_o
);
  localparam logic [OFS_W-1:0] LAST_IDX = OFS_W'(PAYLOAD_BYTES - 1);

  ftr_t             f;
  logic             za_err;
  logic             drop;
  logic             closes;
  logic [OFS_W-1:0] st;

  assign f      = ftr_unpack(ftr_word_i);
  assign za_err = zero_align_i && f.dv && f.sv && (f.swo != '0);
  assign drop   = !f.par_ok || !f.sync || f.fdrop || za_err;
  assign st     = start_byte(f.swo);
  assign closes = open_i && f.ev && (!f.sv || (f.ebo < st));

  always_comb begin
    plan_o      = '0;
    open_next_o = 1'b0;
    if (drop) begin
      plan_o.t_en = open_i;
    end else if (!f.dv) begin
      open_next_o = open_i;
    end else begin
      plan_o.a_en  = open_i && (!f.sv || closes);
      plan_o.a_hi  = closes ? f.ebo : LAST_IDX;
      plan_o.a_eof = closes;
      plan_o.t_en  = open_i && f.sv && !closes;
      plan_o.b_en  = f.sv;
      plan_o.b_lo  = st;
      plan_o.b_eof = f.ev && (f.ebo >= st);
      plan_o.b_hi  = plan_o.b_eof ? f.ebo : LAST_IDX;
      open_next_o  = f.sv ? !plan_o.b_eof : (open_i && !closes);
    end
  end

  assign err_o  = !f.par_ok || f.fdrop || za_err;
  assign exst_o = f.par_ok && f.exst;
  assign upd_o  = f.par_ok;
  assign rca_o  = f.rca;
endmodule

// File: rtl/rxd_emitter.sv
module rxd_emitter
  import rxd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  plan_t            plan_i,
  input  logic             out_ready_i,
  output logic [OFS_W-1:0] idx_o,
  output logic             valid_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic             term_o,
  output logic             idle_o
);
  em_st_e           st_q, st_d;
  logic [OFS_W-1:0] idx_q, idx_d;
  plan_t            plan_q, cur;
  logic             beat;
  logic             seg_done;
  logic             frm_open_q;

  assign beat = valid_o && out_ready_i;
  assign cur  = (st_q == S_IDLE) ? plan_i : plan_q;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    seg_done = 1'b0;
    case (st_q)
      S_IDLE:  seg_done = go_i;
      S_A:     seg_done = beat && (idx_q == plan_q.a_hi);
      S_T:     seg_done = beat;
      S_B:     seg_done = beat && (idx_q == plan_q.b_hi);
      default: seg_done = 1'b0;
    endcase
    if (seg_done) begin
      st_d  = next_seg(cur, st_q);
      idx_d = (st_d == S_B) ? cur.b_lo : '0;
    end else if (beat) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      plan_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (st_q == S_IDLE && go_i) plan_q <= plan_i;
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = st_q != S_IDLE;
  assign idle_o  = st_q == S_IDLE;
  assign term_o  = st_q == S_T;
  assign sof_o   = (st_q == S_B) && (idx_q == plan_q.b_lo);
  assign eof_o   = ((st_q == S_A) && (idx_q == plan_q.a_hi) && plan_q.a_eof) ||
                   (st_q == S_T) ||
                   ((st_q == S_B) && (idx_q == plan_q.b_hi) && plan_q.b_eof);

  // Frame state as seen on the output stream, kept for the check below.
  always_ff @(posedge clk) begin
    if (!rst_n)             frm_open_q <= 1'b0;
    else if (beat && eof_o) frm_open_q <= 1'b0;
    else if (beat && sof_o) frm_open_q <= 1'b1;
  end

  // R7
  no_nested_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof_o) |-> !frm_open_q)
    else $error("frame start while previous frame still open");
endmodule

// File: rtl/rx_chunk_deframer.sv
module rx_chunk_deframer
  import rxd_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_align_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  input  logic             cnt_load_i,
  input  logic [RCA_W-1:0] cnt_load_val_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [7:0]       out_data_o,
  output logic             out_sof_o,
  output logic             out_eof_o,
  output logic             out_err_o,
  output logic             rx_err_o,
  output logic             exst_o,
  output logic [RCA_W-1:0] pend_cnt_o
);
  logic             acc;
  logic             ftr_done;
  logic [31:0]      ftr_word;
  logic [OFS_W-1:0] rd_idx;
  logic [7:0]       rd_byte;
  plan_t            plan;
  logic             open_next, dec_err, dec_exst, dec_upd;
  logic [RCA_W-1:0] dec_rca;
  logic             open_q, rx_err_q, exst_q;
  logic [RCA_W-1:0] pend_q;
  logic             term;

  assign acc = in_valid_i && in_ready_o;

  rxd_capture #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_cap (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .byte_i(in_data_i),
    .rd_idx_i(rd_idx), .rd_byte_o(rd_byte),
    .ftr_done_o(ftr_done), .ftr_word_o(ftr_word)
  );

  rxd_footer_decode #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_dec (
    .ftr_word_i(ftr_word), .open_i(open_q), .zero_align_i(zero_align_i),
    .plan_o(plan), .open_next_o(open_next), .err_o(dec_err),
    .exst_o(dec_exst), .upd_o(dec_upd), .rca_o(dec_rca)
  );

  rxd_emitter u_emit (
    .clk(clk), .rst_n(rst_n), .go_i(ftr_done), .plan_i(plan),
    .out_ready_i(out_ready_i), .idx_o(rd_idx), .valid_o(out_valid_o),
    .sof_o(out_sof_o), .eof_o(out_eof_o), .term_o(term), .idle_o(in_ready_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      rx_err_q <= 1'b0;
      exst_q   <= 1'b0;
      pend_q   <= '0;
    end else begin
      rx_err_q <= ftr_done && dec_err;
      exst_q   <= ftr_done && dec_exst;
      if (ftr_done) open_q <= open_next;
      if (ftr_done && dec_upd) pend_q <= dec_rca;
      if (cnt_load_i) pend_q <= cnt_load_val_i;
    end
  end

  assign out_data_o = term ? 8'h00 : rd_byte;
  assign out_err_o  = term;
  assign rx_err_o   = rx_err_q;
  assign exst_o     = exst_q;
  assign pend_cnt_o = pend_q;

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_sof_o) && $stable(out_eof_o)))
    else $error("beat changed while stalled");

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_load_i && !ftr_done) |=> $stable(pend_cnt_o))
    else $error("pending count moved without footer or load");

  // R3
  par_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ftr_done && !(^ftr_word)) |=> (rx_err_o && $stable(pend_cnt_o)))
    else $error("parity error not reported");

  // R11
  exst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exst_o |=> !exst_o)
    else $error("status pulse longer than one cycle");
endmodule

// File: tb/tb_rx_chunk_deframer.sv
module tb_rx_chunk_deframer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       zero_align, in_valid, in_ready, cnt_load;
  logic [7:0] in_data;
  logic [4:0] cnt_load_val, pend_cnt;
  logic       out_valid, out_ready, out_sof, out_eof, out_err, rx_err, exst;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  rx_chunk_deframer dut (
    .clk(clk), .rst_n(rst_n), .zero_align_i(zero_align),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .cnt_load_i(cnt_load), .cnt_load_val_i(cnt_load_val),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sof_o(out_sof), .out_eof_o(out_eof), .out_err_o(out_err),
    .rx_err_o(rx_err), .exst_o(exst), .pend_cnt_o(pend_cnt)
  );

  int          n_chk = 0, n_fail = 0;
  logic [10:0] exp_q[$];
  logic [10:0] got_q[$];
  logic [7:0]  pl [64];
  logic        m_open = 1'b0;
  logic [4:0]  m_pend = '0;
  logic        e_rxerr, e_exst;
  logic        rdy_rand = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(negedge clk)
    if (rst_n === 1'b1 && out_valid && out_ready)
      got_q.push_back({out_sof, out_eof, out_err, out_data});

  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      out_ready = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  function automatic logic [31:0] mk_ftr(input bit x, input bit fd, input bit sy, input bit dv,
      input bit sv, input int swo, input bit ev, input int ebo, input int rca, input bit badp);
    logic [31:0] w = '0;
    w[31] = x; w[30] = fd; w[29] = sy; w[21] = dv; w[20] = sv;
    w[19:16] = swo[3:0]; w[14] = ev; w[13:8] = ebo[5:0]; w[5:1] = rca[4:0];
    w[0] = ($countones(w) % 2 == 0);
    if (badp) w[0] = ~w[0];
    return w;
  endfunction

  // Per-byte model of one chunk.
  task automatic model(input logic [31:0] w);
    bit par_ok = ($countones(w) % 2) == 1;
    bit sv = w[20], ev = w[14];
    int st = w[19:16] * 4, ebo = w[13:8];
    bit za_err = zero_align && w[21] && sv && (w[19:16] != 0);
    bit cur, sofn;
    e_rxerr = !par_ok || w[30] || za_err;
    e_exst  = par_ok && w[31];
    if (par_ok) m_pend = w[5:1];
    if (!par_ok || !w[29] || w[30] || za_err) begin
      if (m_open) exp_q.push_back({3'b011, 8'h00});
      m_open = 1'b0;
    end else if (w[21]) begin
      cur = m_open;
      if (cur && sv && !(ev && ebo < st)) begin
        exp_q.push_back({3'b011, 8'h00});
        cur = 1'b0;
      end
      for (int i = 0; i < 64; i++) begin
        sofn = 1'b0;
        if (sv && i == st) begin cur = 1'b1; sofn = 1'b1; end
        if (cur) begin
          exp_q.push_back({sofn, ev && i == ebo, 1'b0, pl[i]});
          if (ev && i == ebo) cur = 1'b0;
        end
      end
      m_open = cur;
    end
  endtask

  task automatic run_chunk(input logic [31:0] w, input string tag);
    int guard;
    int bad;
    for (int i = 0; i < 64; i++) pl[i] = 8'($urandom);
    model(w);
    for (int k = 0; k < 68; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = (k < 64) ? pl[k] : w[8*(67-k) +: 8];
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(rx_err == e_rxerr, {tag, " R3 R9 R10 rx_err"}, rx_err, e_rxerr);
    check(exst == e_exst, "R11 exst", exst, e_exst);
    check(pend_cnt == m_pend, "R4 pend", pend_cnt, m_pend);
    check(in_ready == (exp_q.size() == 0), "R1 in_ready", in_ready, exp_q.size() == 0);
    guard = 0;
    while (!in_ready && guard < 2000) begin @(negedge clk); guard++; end
    bad = (got_q.size() != exp_q.size()) ? 1 : 0;
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (got_q[i] !== exp_q[i] && bad == 0) begin
        bad = 1;
        $display("FAIL %s beat %0d actual=%0h expected=%0h", tag, i, got_q[i], exp_q[i]);
      end
    check(bad == 0, {tag, " beats"}, got_q.size(), exp_q.size());
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    void'($urandom(32'd20240917));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; cnt_load = 1'b0;
    cnt_load_val = '0; zero_align = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    check(pend_cnt == 5'd0, "R4 reset pend", pend_cnt, 0);
    check(rx_err == 1'b0, "R3 reset rx_err", rx_err, 0);

    // R4: buffer-status load
    cnt_load = 1'b1; cnt_load_val = 5'd19;
    @(negedge clk) cnt_load = 1'b0;
    check(pend_cnt == 5'd19, "R4 load", pend_cnt, 19);
    m_pend = 5'd19;

    // R5: start mid-payload and end in same chunk; R2 field layout
    run_chunk(mk_ftr(0,0,1,1,1,3,1,40,7,0), "R5 R2");
    run_chunk(mk_ftr(0,0,1,1,1,1,1,4,6,0), "R5 single");
    // R6: open frame, full continuation, then end
    run_chunk(mk_ftr(0,0,1,1,1,2,0,0,5,0), "R5 open");
    run_chunk(mk_ftr(0,0,1,1,0,0,0,0,4,0), "R6 full");
    run_chunk(mk_ftr(0,0,1,1,0,0,1,5,3,0), "R6 end");
    // R7: end before new start; then start while open without end
    run_chunk(mk_ftr(0,0,1,1,1,0,0,0,3,0), "R7 setup");
    run_chunk(mk_ftr(0,0,1,1,1,8,1,10,3,0), "R7 close");
    run_chunk(mk_ftr(0,0,1,1,1,5,0,0,3,0), "R7 term");
    // R8: no data while open; orphan continuation
    run_chunk(mk_ftr(0,0,1,0,0,0,0,0,2,0), "R8 dv0");
    run_chunk(mk_ftr(0,0,1,1,0,0,1,9,2,0), "R8 close");
    run_chunk(mk_ftr(0,0,1,1,0,0,0,0,2,0), "R8 orphan");
    // R3: bad parity while open
    run_chunk(mk_ftr(0,0,1,1,1,0,0,0,9,0), "R3 setup");
    run_chunk(mk_ftr(0,0,1,1,0,0,1,3,30,1), "R3 parity");
    // R9: sync low while open, frame-drop while open
    run_chunk(mk_ftr(0,0,1,1,1,4,0,0,8,0), "R9 setup");
    run_chunk(mk_ftr(0,0,0,1,0,0,1,3,8,0), "R9 nosync");
    run_chunk(mk_ftr(0,0,1,1,1,4,0,0,8,0), "R9 setup2");
    run_chunk(mk_ftr(0,1,1,1,0,0,1,3,8,0), "R9 fdrop");
    // R10: zero-align mode
    zero_align = 1'b1;
    run_chunk(mk_ftr(0,0,1,1,1,0,0,0,1,0), "R10 ok");
    run_chunk(mk_ftr(0,0,1,1,1,2,1,30,1,0), "R10 bad");
    run_chunk(mk_ftr(0,0,1,1,1,0,1,63,1,0), "R10 full");
    zero_align = 1'b0;
    // R11: extended status
    run_chunk(mk_ftr(1,0,1,0,0,0,0,0,11,0), "R11 exst");
    run_chunk(mk_ftr(1,0,1,0,0,0,0,0,11,1), "R11 badpar");

    // R12: random chunks with consumer stalls
    rdy_rand = 1'b1;
    for (int n = 0; n < 160; n++) begin
      bit sv = ($urandom % 5) < 2;
      if (n % 20 == 0) zero_align = ($urandom % 3 == 0);
      run_chunk(mk_ftr($urandom % 10 == 0, $urandom % 20 == 0, $urandom % 10 != 0,
                       $urandom % 7 != 0, sv,
                       (zero_align && ($urandom % 4 != 0)) ? 0 : int'($urandom % 16),
                       ($urandom % 5) < 2, int'($urandom % 64), int'($urandom % 32),
                       $urandom % 20 == 0), "R12 R2 random");
    end
    rdy_rand = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule